// File: doc/BRIEF.md
# Microcoded 8-bit ALU with Status Register

This block is the arithmetic stage of a small microprogrammed 8-bit processor. Each cycle the microsequencer presents two operand bytes, a 6-bit operation code, a 3-bit vector index taken from the instruction register, a 2-bit status-update mask and two aux-carry controls. At the next clock edge the block registers an 8-bit result and updates an 8-bit status byte. The status byte holds carry, aux carry, zero, sign and even parity.

Besides add, subtract, logic and rotate operations, the block has several operations for microcode use. It can pass an operand through, build a restart vector and read back the status byte. It can also set or complement the carry, and it runs a decimal adjust that needs two consecutive issues. Operand sourcing and register write-back belong to the surrounding datapath.

Top module: `ucalu8`

## Requirements
- R1: While reset is held and directly after it, `res_o` is 0x00 and `status_o` is 0x02. Status bit positions are sign 7, zero 6, aux carry 4, parity 2, carry 0. Bit 1 reads 1 and bits 3 and 5 read 0 at all times.
- R2: Operation 001100 yields T2+T1 and operation 001101 yields T2+T1+cin. The result and the new status appear one clock after issue. The new carry is the carry out of bit 7.
- R3: Operation 001110 yields T2−T1 and operation 001111 yields T2−T1−cin. The new carry is the borrow, which is 1 when the true difference is negative.
- R4: Operations 000100, 000101 and 000111 give T1 AND T2, T1 OR T2 and T1 XOR T2, with carry 0 and aux carry 0. Operation 000110 gives NOT T1 and leaves the carry unchanged.
- R5: Operation 000000 rotates T1 left and operation 000001 rotates T1 right, with the bit shifted out copied to carry. Operations 000010 and 000011 rotate left and right through cin.
- R6: Operation 010111 returns T1. Operation 011111 returns 8×vec_i. Operation 110000 returns the status byte held before the edge. All three leave the carry unchanged.
- R7: Operation 101100 complements the carry and operation 101101 sets it. Both obey mask bit 0, and neither changes sign, zero, parity or aux carry, whatever the mask.
- R8: When the flags other than carry are updated, sign is result bit 7, zero is 1 for a zero result, and parity is 1 for an even count of ones. Aux carry is the carry (or borrow) out of bit 3 for add and subtract operations, and 0 for operations other than add, subtract and decimal adjust.
- R9: Mask bit 0 enables the carry update. Mask bit 1 enables the update of sign, zero, parity and aux carry. Flags that are not enabled keep their values.
- R10: cin is normally the stored carry. With aux_cin_i high, cin is the aux carry instead. With aux_set_i high, the aux carry counts as 1 for this operation, and it is stored as 1 unless mask bit 1 overwrites it.
- R11: Operation 101000 issued in two consecutive cycles returns, after the second issue, the decimal adjust of the T1 presented at the first issue. The correction uses the carry and aux carry held at the first issue. 0x06 is added if the low digit exceeds 9 or aux carry is set. 0x60 is added, and the carry becomes 1, if T1 exceeds 0x99 or carry is set; otherwise the carry is kept. Aux carry becomes the carry out of bit 3 of the correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 6 | Operation code |
| t1_i | input | 8 | Operand T1 |
| t2_i | input | 8 | Operand T2 |
| vec_i | input | 3 | Restart vector index |
| upd_mask_i | input | 2 | Status update mask |
| aux_cin_i | input | 1 | Use aux carry as carry-in |
| aux_set_i | input | 1 | Force aux carry to 1 for this operation |
| res_o | output | 8 | Registered result |
| status_o | output | 8 | Status byte |

## Verification
The add and subtract operations are swept over every T1 value against a set of T2 corner values. The set includes 0x00, 0x0F, 0x10, 0x7F, 0x80 and 0xFF, and each case is run with the carry clear and set, so carry, borrow, half-carry and zero boundaries are all separated. Logic and rotate operations see every T1 with both carry states, which distinguishes circular from through-carry rotation. Decimal adjust is swept over all 256 inputs for all four carry and aux-carry combinations. The second issue presents a different T1, which exposes a design that reads its operand too late. Mask and aux-carry cases use operands whose flags differ from the held state, so a flag that is wrongly kept or wrongly written shows up.

// File: rtl/ucalu_pkg.sv
package ucalu_pkg;
    localparam int DW = 8;
    localparam int VW = 3;
    localparam int OPW = 6;

    localparam int SB_CY = 0;
    localparam int SB_ONE = 1;
    localparam int SB_P = 2;
    localparam int SB_AC = 4;
    localparam int SB_Z = 6;
    localparam int SB_S = 7;

    localparam logic [DW-1:0] STATUS_RST = 8'h02;

    typedef enum logic [OPW-1:0] {
        OP_RLC  = 6'b000000,
        OP_RRC  = 6'b000001,
        OP_RAL  = 6'b000010,
        OP_RAR  = 6'b000011,
        OP_AND  = 6'b000100,
        OP_OR   = 6'b000101,
        OP_NOT  = 6'b000110,
        OP_XOR  = 6'b000111,
        OP_ADD  = 6'b001100,
        OP_ADC  = 6'b001101,
        OP_SUB  = 6'b001110,
        OP_SBB  = 6'b001111,
        OP_PASS = 6'b010111,
        OP_VEC  = 6'b011111,
        OP_DAA  = 6'b101000,
        OP_CMC  = 6'b101100,
        OP_STC  = 6'b101101,
        OP_PSW  = 6'b110000
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] st;
    } alu_state_t;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          cy;
        logic          ac;
    } dec_stage_t;
endpackage

// File: rtl/ucalu_addsub.sv
module ucalu_addsub
    import ucalu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          hc_o
);
    localparam int FW = DW + 1;
    localparam int HW = DW / 2;
    localparam int HW1 = HW + 1;

    logic [DW:0] full;
    logic [HW:0] half;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - FW'(cin_i);
            half = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - HW1'(cin_i);
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + FW'(cin_i);
            half = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + HW1'(cin_i);
        end
        sum_o  = full[DW-1:0];
        cout_o = full[DW];
        hc_o   = half[HW];
    end
endmodule

// File: rtl/ucalu_bitops.sv
module ucalu_bitops
    import ucalu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic [2:0]    sel_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);
    always_comb begin
        res_o  = a_i;
        cout_o = 1'b0;
        case (sel_i)
            3'd0: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cout_o = a_i[DW-1]; end
            3'd1: begin res_o = {a_i[0], a_i[DW-1:1]};    cout_o = a_i[0];    end
            3'd2: begin res_o = {a_i[DW-2:0], cin_i};     cout_o = a_i[DW-1]; end
            3'd3: begin res_o = {cin_i, a_i[DW-1:1]};     cout_o = a_i[0];    end
            3'd4: res_o = a_i & b_i;
            3'd5: res_o = a_i | b_i;
            3'd6: res_o = ~a_i;
            default: res_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/ucalu_decadj.sv
module ucalu_decadj
    import ucalu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [DW-1:0] val_i,
    input  logic          cy_i,
    input  logic          ac_i,
    output dec_stage_t    stage_o
);
    localparam int HW = DW / 2;
    localparam logic [HW-1:0] DIGIT_MAX = HW'(9);
    localparam logic [DW-1:0] BYTE_MAX = {DIGIT_MAX, DIGIT_MAX};
    localparam logic [HW-1:0] DIGIT_FIX = HW'(6);

    dec_stage_t stage_d, stage_q;
    logic [DW-1:0] corr;
    logic [HW:0]   low_sum;
    logic          cy_new;

    always_comb begin
        corr   = '0;
        cy_new = cy_i;
        if (val_i[HW-1:0] > DIGIT_MAX || ac_i) corr[HW-1:0] = DIGIT_FIX;
        if (val_i > BYTE_MAX || cy_i) begin
            corr[DW-1:HW] = DIGIT_FIX;
            cy_new = 1'b1;
        end
        low_sum = {1'b0, val_i[HW-1:0]} + {1'b0, corr[HW-1:0]};
        stage_d = stage_q;
        if (issue_i) begin
            stage_d.val = val_i + corr;
            stage_d.cy  = cy_new;
            stage_d.ac  = low_sum[HW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign stage_o = stage_q;

    // R11: a valid BCD byte with no pending carries passes through unchanged
    assert_daa_bcd_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !cy_i && !ac_i && val_i[HW-1:0] <= DIGIT_MAX && val_i[DW-1:HW] <= DIGIT_MAX)
        |=> (stage_o.val == $past(val_i) && !stage_o.cy));
endmodule

// File: rtl/ucalu8.sv
module ucalu8
    import ucalu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  t1_i,
    input  logic [DW-1:0]  t2_i,
    input  logic [VW-1:0]  vec_i,
    input  logic [1:0]     upd_mask_i,
    input  logic           aux_cin_i,
    input  logic           aux_set_i,
    output logic [DW-1:0]  res_o,
    output logic [DW-1:0]  status_o
);
    localparam int VSH = 3;

    alu_state_t state_d, state_q;
    dec_stage_t dec_stage;

    logic          ac_eff, cin;
    logic          is_sub, use_cin, is_daa;
    logic [DW-1:0] as_sum, bo_res;
    logic          as_cout, as_hc, bo_cout;
    logic [DW-1:0] res_n;
    logic          cy_n, ac_n, carry_only;

    assign ac_eff  = aux_set_i | state_q.st[SB_AC];
    assign cin     = aux_cin_i ? ac_eff : state_q.st[SB_CY];
    assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SBB);
    assign use_cin = (op_i == OP_ADC) || (op_i == OP_SBB);
    assign is_daa  = (op_i == OP_DAA);

    ucalu_addsub u_addsub (
        .a_i   (t2_i),
        .b_i   (t1_i),
        .cin_i (use_cin & cin),
        .sub_i (is_sub),
        .sum_o (as_sum),
        .cout_o(as_cout),
        .hc_o  (as_hc)
    );

    ucalu_bitops u_bitops (
        .a_i   (t1_i),
        .b_i   (t2_i),
        .cin_i (cin),
        .sel_i (op_i[2:0]),
        .res_o (bo_res),
        .cout_o(bo_cout)
    );

    ucalu_decadj u_decadj (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue_i(is_daa),
        .val_i  (t1_i),
        .cy_i   (state_q.st[SB_CY]),
        .ac_i   (state_q.st[SB_AC]),
        .stage_o(dec_stage)
    );

    always_comb begin
        res_n      = t1_i;
        cy_n       = state_q.st[SB_CY];
        ac_n       = 1'b0;
        carry_only = 1'b0;
        case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res_n = as_sum;
                cy_n  = as_cout;
                ac_n  = as_hc;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_AND, OP_OR, OP_XOR: begin
                res_n = bo_res;
                cy_n  = bo_cout;
            end
            OP_NOT:  res_n = bo_res;
            OP_VEC:  res_n = {{(DW-VW-VSH){1'b0}}, vec_i, {VSH{1'b0}}};
            OP_PSW:  res_n = state_q.st;
            OP_DAA: begin
                res_n = dec_stage.val;
                cy_n  = dec_stage.cy;
                ac_n  = dec_stage.ac;
            end
            OP_CMC: begin cy_n = ~state_q.st[SB_CY]; carry_only = 1'b1; end
            OP_STC: begin cy_n = 1'b1;                carry_only = 1'b1; end
            default: res_n = t1_i;
        endcase

        state_d.res = res_n;
        state_d.st  = state_q.st;
        if (aux_set_i) state_d.st[SB_AC] = 1'b1;
        if (upd_mask_i[0]) state_d.st[SB_CY] = cy_n;
        if (upd_mask_i[1] && !carry_only) begin
            state_d.st[SB_S]  = res_n[DW-1];
            state_d.st[SB_Z]  = (res_n == '0);
            state_d.st[SB_P]  = ~^res_n;
            state_d.st[SB_AC] = ac_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.res <= '0;
            state_q.st  <= STATUS_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o    = state_q.res;
    assign status_o = state_q.st;

    assert_carry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_mask_i[0] |=> $stable(status_o[SB_CY]));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_mask_i[1] |=> $stable({status_o[SB_S], status_o[SB_Z], status_o[SB_P]}));

    assert_cmc_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMC && upd_mask_i[0]) |=> (status_o[SB_CY] != $past(status_o[SB_CY])));

    assert_stc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STC && upd_mask_i[0]) |=> status_o[SB_CY]);

    assert_carry_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_CMC || op_i == OP_STC) && !aux_set_i)
        |=> $stable({status_o[SB_S], status_o[SB_Z], status_o[SB_AC], status_o[SB_P]}));

    assert_vec_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_VEC) |=> (res_o[VSH-1:0] == '0 && res_o[DW-1:VW+VSH] == '0));

    assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[SB_ONE] && !status_o[3] && !status_o[5]);
endmodule

// File: tb/ucalu8_test.sv
`timescale 1ns/1ps
module ucalu8_test;
    import ucalu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op = 6'b010111;
    logic [7:0] t1 = '0, t2 = '0;
    logic [2:0] vec = '0;
    logic [1:0] mask = '0;
    logic       ua = 1'b0, fa = 1'b0;
    logic [7:0] res_o, status_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [7:0] exp_st;

    always #2 clk = ~clk;

    ucalu8 uut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .t1_i(t1), .t2_i(t2),
        .vec_i(vec), .upd_mask_i(mask), .aux_cin_i(ua), .aux_set_i(fa),
        .res_o(res_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] model(input logic [5:0] o, input logic [7:0] a, input logic [7:0] b,
                                          input logic [2:0] v, input logic [1:0] m, input logic u,
                                          input logic f, input logic [7:0] st);
        int s;
        logic c, cy, ac, co;
        logic [7:0] r, ns;
        c  = u ? (f | st[4]) : st[0];
        cy = st[0];
        ac = 1'b0;
        co = 1'b0;
        r  = a;
        case (o)
            6'b001100, 6'b001101: begin
                s  = int'(b) + int'(a) + ((o == 6'b001101) ? int'(c) : 0);
                r  = s[7:0]; cy = (s > 255);
                ac = ((int'(b[3:0]) + int'(a[3:0]) + ((o == 6'b001101) ? int'(c) : 0)) > 15);
            end
            6'b001110, 6'b001111: begin
                s  = int'(b) - int'(a) - ((o == 6'b001111) ? int'(c) : 0);
                r  = s[7:0]; cy = (s < 0);
                ac = ((int'(b[3:0]) - int'(a[3:0]) - ((o == 6'b001111) ? int'(c) : 0)) < 0);
            end
            6'b000100: begin r = a & b; cy = 0; end
            6'b000101: begin r = a | b; cy = 0; end
            6'b000111: begin r = a ^ b; cy = 0; end
            6'b000110: r = ~a;
            6'b000000: begin r = (a << 1) | (a >> 7); cy = a[7]; end
            6'b000001: begin r = (a >> 1) | (a << 7); cy = a[0]; end
            6'b000010: begin r = (a << 1) | {7'd0, c}; cy = a[7]; end
            6'b000011: begin r = (a >> 1) | {c, 7'd0}; cy = a[0]; end
            6'b011111: r = 8'(int'(v) * 8);
            6'b110000: r = st;
            6'b101100: begin cy = ~st[0]; co = 1; end
            6'b101101: begin cy = 1'b1;   co = 1; end
            default: r = a;
        endcase
        ns = st;
        if (f) ns[4] = 1'b1;
        if (m[0]) ns[0] = cy;
        if (m[1] && !co) begin
            ns[7] = r[7];
            ns[6] = (r == 8'd0);
            ns[2] = ~^r;
            ns[4] = ac;
        end
        return {r, ns};
    endfunction

    task automatic run(input logic [5:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] v, input logic [1:0] m, input logic u, input logic f,
                       input string tag);
        logic [15:0] e;
        e = model(o, a, b, v, m, u, f, exp_st);
        op = o; t1 = a; t2 = b; vec = v; mask = m; ua = u; fa = f;
        @(negedge clk);
        if (o != 6'b101100 && o != 6'b101101)
            chk(res_o === e[15:8], {tag, " result"}, res_o, e[15:8]);
        chk(status_o === e[7:0], {tag, " status"}, status_o, e[7:0]);
        exp_st = e[7:0];
    endtask

    function automatic logic [7:0] corner(input int i);
        case (i)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h0F; 3: return 8'h10;
            4: return 8'h7F; 5: return 8'h80; 6: return 8'hF0; default: return 8'hFF;
        endcase
    endfunction

    task automatic set_carry(input bit c, input string tag);
        run(6'b101101, 8'h00, 8'h00, 3'd0, 2'b01, 1'b0, 1'b0, tag);
        if (!c) run(6'b101100, 8'h00, 8'h00, 3'd0, 2'b01, 1'b0, 1'b0, tag);
    endtask

    task automatic daa_pair(input logic [7:0] a);
        logic [7:0] corr, r, ns;
        logic cout;
        int lo;
        lo = int'(a[3:0]);
        corr = 8'h00;
        cout = exp_st[0];
        if (lo > 9 || exp_st[4]) corr = 8'h06;
        if (a > 8'h99 || exp_st[0]) begin corr = corr + 8'h60; cout = 1'b1; end
        r = a + corr;
        ns = exp_st;
        ns[0] = cout;
        ns[4] = ((lo + int'(corr[3:0])) > 15);
        ns[7] = r[7]; ns[6] = (r == 8'd0); ns[2] = ~^r;
        op = 6'b101000; t1 = a; mask = 2'b00; ua = 0; fa = 0;
        @(negedge clk);
        chk(status_o === exp_st, "R11 first issue status", status_o, exp_st);
        t1 = ~a; mask = 2'b11;
        @(negedge clk);
        chk(res_o === r, "R11 adjusted result", res_o, r);
        chk(status_o === ns, "R11 adjusted status", status_o, ns);
        exp_st = ns;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(res_o === 8'h00, "R1 reset result", res_o, 8'h00);
        chk(status_o === 8'h02, "R1 reset status", status_o, 8'h02);
        rst_n = 1'b1;
        exp_st = 8'h02;
        @(negedge clk);
        chk(res_o === 8'h00 && status_o === 8'h02, "R1 after release", status_o, 8'h02);

        // R2 / R3 / R8: add and subtract sweeps with carry clear and set
        for (int oi = 0; oi < 4; oi++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int bi = 0; bi < 8; bi++) begin
                        set_carry(c[0], "R7 carry prep");
                        run(6'b001100 + 6'(oi), 8'(a), corner(bi), 3'd0, 2'b11, 1'b0, 1'b0,
                            (oi < 2) ? "R2 add" : "R3 sub");
                    end
                end
            end
        end

        // R4 / R5: logic and rotate ops over every T1, both carry states
        for (int oi = 0; oi < 8; oi++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 256; a++) begin
                    set_carry(c[0], "R7 carry prep");
                    run(6'(oi), 8'(a), 8'(a * 29 + 7), 3'd0, 2'b11, 1'b0, 1'b0,
                        (oi < 4) ? "R5 rotate" : "R4 logic");
                end
            end
        end

        // R6: pass, vector, status readout
        set_carry(1'b1, "R6 prep");
        run(6'b010111, 8'hA5, 8'h00, 3'd0, 2'b11, 1'b0, 1'b0, "R6 pass");
        for (int v = 0; v < 8; v++)
            run(6'b011111, 8'h5A, 8'h00, 3'(v), 2'b11, 1'b0, 1'b0, "R6 vector");
        run(6'b110000, 8'h00, 8'h00, 3'd0, 2'b00, 1'b0, 1'b0, "R6 status readout");
        run(6'b110000, 8'h00, 8'h00, 3'd0, 2'b11, 1'b0, 1'b0, "R6 status readout");

        // R7: carry ops keep other flags even with full mask
        run(6'b001100, 8'h0F, 8'h01, 3'd0, 2'b11, 1'b0, 1'b0, "R7 prep");
        run(6'b101100, 8'h00, 8'h00, 3'd0, 2'b11, 1'b0, 1'b0, "R7 complement");
        run(6'b101100, 8'h00, 8'h00, 3'd0, 2'b11, 1'b0, 1'b0, "R7 complement");
        run(6'b101101, 8'h00, 8'h00, 3'd0, 2'b10, 1'b0, 1'b0, "R7 set masked off");
        run(6'b101101, 8'h00, 8'h00, 3'd0, 2'b11, 1'b0, 1'b0, "R7 set");

        // R9: each mask value against a state whose flags differ
        for (int m = 0; m < 4; m++) begin
            run(6'b001100, 8'h01, 8'h02, 3'd0, 2'b11, 1'b0, 1'b0, "R9 prep");
            run(6'b001100, 8'h80, 8'h80, 3'd0, 2'(m), 1'b0, 1'b0, "R9 mask");
            run(6'b001110, 8'h01, 8'h00, 3'd0, 2'(m), 1'b0, 1'b0, "R9 mask");
        end

        // R10: aux carry as carry-in, forced aux carry
        run(6'b001100, 8'h00, 8'h00, 3'd0, 2'b11, 1'b0, 1'b0, "R10 prep");
        set_carry(1'b1, "R10 prep");
        run(6'b001101, 8'h34, 8'h00, 3'd0, 2'b00, 1'b1, 1'b0, "R10 aux cin clear");
        run(6'b001101, 8'h34, 8'h00, 3'd0, 2'b00, 1'b1, 1'b1, "R10 aux forced");
        run(6'b001101, 8'h10, 8'h00, 3'd0, 2'b00, 1'b1, 1'b0, "R10 aux held");
        run(6'b000010, 8'h40, 8'h00, 3'd0, 2'b01, 1'b1, 1'b0, "R10 rotate aux cin");
        run(6'b001111, 8'h01, 8'h10, 3'd0, 2'b11, 1'b1, 1'b1, "R10 sbb forced");

        // R11: decimal adjust over all inputs and flag combinations
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 256; a++) begin
                run(6'b001100, k[1] ? 8'h01 : 8'h00, 8'h0F, 3'd0, 2'b11, 1'b0, 1'b0, "R11 prep");
                if (k[0]) run(6'b101101, 8'h00, 8'h00, 3'd0, 2'b01, 1'b0, 1'b0, "R11 prep");
                daa_pair(8'(a));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule